// File: doc/BRIEF.md
# Register-Driven I2C Bus Master

This block is an I2C bus master that a processor runs entirely through a small word-indexed register file. Software loads a 7-bit target address, an optional one-byte register offset, a byte count and a clock setup. It then writes a transfer mode to the start register. The controller produces the START, the address byte, the optional offset byte, the data bytes and the STOP on SCL and SDA. SDA is open drain: each output means 1 = release and 0 = pull low.

Data moves through single-byte holding registers instead of a FIFO. On a write, the controller takes the byte waiting in the data-out register and raises an "empty" flag, and software refills the register. If no byte is waiting when one is needed, SCL is held low until one arrives. On a read, each received byte lands in the data-in register and raises a "ready" flag, which a read of data-in clears.

The register indices are: 0 config, 1 clock divider, 2 target address, 3 offset byte, 4 data out, 5 data in, 6 status, 7 start, 8 byte count, 9 start-hold time. The status bits are: 0 busy, 1 data-out empty, 2 received byte ready, 3 acknowledge error, 4 start error, 5 always zero.

Top module: `i2cm_ctrl`

## Requirements
- R1: After reset, status reads 0x02, the divider reads 0x52, the start-hold register reads 0, and SCL and SDA are both released.
- R2: Writing 0, 1 or 2 to index 7 starts a write, a read or an address-only transfer. Status bit 0 is set from the next cycle until the STOP completes. A start write made while busy is ignored, and so is a write of the value 3. When not busy, both lines stay released.
- R3: A transfer opens with SDA falling while SCL is high. SCL then stays high for hold+1 system clocks before it falls.
- R4: Every SCL high phase of an address, offset or data bit lasts divider+1 system clocks.
- R5: The first byte is the 7-bit target address followed by a direction bit, sent MSB first. The direction bit is 1 only for a read.
- R6: When config bit 1 is 0, write and address-only transfers send the offset byte right after the address. When config bit 1 is 1, the offset is skipped. Reads never send the offset.
- R7: A write sends byte-count data bytes taken from data-out. Taking a byte sets status bit 1, and writing data-out clears it. When a byte is needed and none is waiting, SCL is held low until software writes one.
- R8: A read receives byte-count bytes. Each byte appears at index 5 with status bit 2 set, and reading index 5 clears bit 2. The master acknowledges every byte except the last, which it does not acknowledge.
- R9: An address-only transfer has no data phase, whatever the byte count. The STOP follows the address byte, or the offset byte when one is sent.
- R10: If the target does not acknowledge a transmitted byte, the master issues a STOP and clears busy. Status bit 3 stays set until the next accepted start write.
- R11: If SDA is low when a start is accepted, the master drives neither line, busy stays clear, and status bit 4 is set until the next accepted start write.
- R12: Every transfer ends with SDA rising while SCL is high. Busy drops afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_idx | input | 4 | Word index of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, registered one cycle after reg_rd |
| scl_o | output | 1 | SCL drive: 1 release, 0 pull low |
| sda_o | output | 1 | SDA drive: 1 release, 0 pull low |
| sda_i | input | 1 | Sensed SDA line level |

## Verification
The bench attacks the following corner cases:
- A write whose data-out register is empty when a byte is due. A design that does not stall would clock out a stale byte instead of holding SCL low.
- A read with the offset bit clear. A design that wrongly inserts the offset would show an extra byte on the bus.
- An address-only transfer with a non-zero byte count. A design that leaks into a data phase would add bytes before the STOP.
- Acknowledge-error and start-error stickiness. A bit that clears on any register write, or that fails to clear on the next start, is caught by status reads around those writes.
- The acknowledge bit on the last received byte. A design that acknowledges the final byte is caught on the bus.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int REG_IDX_W = 4;

  localparam logic [REG_IDX_W-1:0] IX_CFG   = 4'd0;
  localparam logic [REG_IDX_W-1:0] IX_DIV   = 4'd1;
  localparam logic [REG_IDX_W-1:0] IX_DEV   = 4'd2;
  localparam logic [REG_IDX_W-1:0] IX_OFS   = 4'd3;
  localparam logic [REG_IDX_W-1:0] IX_DOUT  = 4'd4;
  localparam logic [REG_IDX_W-1:0] IX_DIN   = 4'd5;
  localparam logic [REG_IDX_W-1:0] IX_STAT  = 4'd6;
  localparam logic [REG_IDX_W-1:0] IX_GO    = 4'd7;
  localparam logic [REG_IDX_W-1:0] IX_CNT   = 4'd8;
  localparam logic [REG_IDX_W-1:0] IX_HOLD  = 4'd9;

  // bit of the config register that suppresses the offset phase
  localparam int CFG_SKIP_BIT = 1;

  typedef enum logic [1:0] {
    XF_WRITE = 2'd0,
    XF_READ  = 2'd1,
    XF_ADDR  = 2'd2
  } xfer_mode_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_OFS,
    PH_DATA
  } byte_phase_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_LOW,
    ST_HIGH,
    ST_LOAD,
    ST_P_LOW,
    ST_P_HIGH,
    ST_P_END
  } bus_state_e;
endpackage

// File: rtl/i2cm_timer.sv
module i2cm_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic [W-1:0] span,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (restart)      cnt_q <= span;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int TMR_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  xfer_mode_e       mode_in,
  input  logic             skip_ofs,
  input  logic [6:0]       dev_addr,
  input  logic [7:0]       ofs_byte,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic [TMR_W-1:0] div_val,
  input  logic [TMR_W-1:0] hold_val,
  input  logic [7:0]       tx_byte,
  input  logic             tx_full,
  output logic             tx_take,
  output logic [7:0]       rx_byte,
  output logic             rx_valid,
  output logic             nack_hit,
  output logic             start_err,
  output logic             busy,
  output logic             scl_o,
  output logic             sda_o,
  input  logic             sda_i
);
  localparam logic [3:0] ACK_SLOT = 4'd8;

  bus_state_e       st_q;
  byte_phase_e      ph_q, ph_nx;
  xfer_mode_e       mode_q;
  logic [7:0]       sh_q;
  logic [3:0]       bit_q;
  logic             tx_q, last_q;
  logic [CNT_W-1:0] rem_q;
  logic             tmr_done, hop, load_ok, to_stop, out_bit, byte_end;

  assign load_ok = (ph_q != PH_DATA) || (mode_q == XF_READ) || tx_full;
  assign hop = (st_q == ST_IDLE) ? (go && sda_i) :
               (st_q == ST_LOAD) ? load_ok : tmr_done;

  i2cm_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .restart(hop),
    .span((st_q == ST_IDLE) ? hold_val : div_val),
    .expired(tmr_done)
  );

  // choose the byte that follows the one just finished
  always_comb begin
    ph_nx   = PH_DATA;
    to_stop = 1'b0;
    case (ph_q)
      PH_ADDR: begin
        if (mode_q != XF_READ && !skip_ofs)       ph_nx = PH_OFS;
        else if (mode_q == XF_ADDR || rem_q == '0) to_stop = 1'b1;
      end
      PH_OFS:  if (mode_q == XF_ADDR || rem_q == '0) to_stop = 1'b1;
      default: if (rem_q == CNT_W'(1)) to_stop = 1'b1;
    endcase
  end

  assign out_bit   = tx_q ? ((bit_q == ACK_SLOT) ? 1'b1 : sh_q[7])
                          : ((bit_q == ACK_SLOT) ? last_q : 1'b1);
  assign byte_end  = (st_q == ST_HIGH) && tmr_done && (bit_q == ACK_SLOT);
  assign nack_hit  = byte_end && tx_q && sda_i;
  assign rx_valid  = byte_end && !tx_q;
  assign rx_byte   = sh_q;
  assign tx_take   = (st_q == ST_LOAD) && (ph_q == PH_DATA) &&
                     (mode_q != XF_READ) && tx_full;
  assign start_err = (st_q == ST_IDLE) && go && !sda_i;
  assign busy      = (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_ADDR;
      mode_q <= XF_WRITE;
      sh_q   <= '0;
      bit_q  <= '0;
      tx_q   <= 1'b1;
      last_q <= 1'b0;
      rem_q  <= '0;
      scl_o  <= 1'b1;
      sda_o  <= 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: if (hop) begin
          st_q   <= ST_HOLD;
          sda_o  <= 1'b0;
          sh_q   <= {dev_addr, mode_in == XF_READ};
          tx_q   <= 1'b1;
          bit_q  <= '0;
          ph_q   <= PH_ADDR;
          rem_q  <= byte_cnt;
          mode_q <= mode_in;
        end
        ST_HOLD: if (hop) begin
          scl_o <= 1'b0;
          st_q  <= ST_LOW;
        end
        ST_LOW: begin
          sda_o <= out_bit;
          if (hop) begin
            scl_o <= 1'b1;
            st_q  <= ST_HIGH;
          end
        end
        ST_HIGH: if (hop) begin
          scl_o <= 1'b0;
          if (bit_q != ACK_SLOT) begin
            sh_q  <= {sh_q[6:0], sda_i};
            bit_q <= bit_q + 1'b1;
            st_q  <= ST_LOW;
          end else begin
            if (ph_q == PH_DATA) rem_q <= rem_q - 1'b1;
            ph_q <= ph_nx;
            st_q <= (nack_hit || to_stop) ? ST_P_LOW : ST_LOAD;
          end
        end
        ST_LOAD: if (hop) begin
          bit_q <= '0;
          st_q  <= ST_LOW;
          if (ph_q == PH_OFS) begin
            sh_q <= ofs_byte;
            tx_q <= 1'b1;
          end else if (mode_q == XF_READ) begin
            tx_q   <= 1'b0;
            last_q <= (rem_q == CNT_W'(1));
          end else begin
            sh_q <= tx_byte;
            tx_q <= 1'b1;
          end
        end
        ST_P_LOW: begin
          sda_o <= 1'b0;
          if (hop) begin
            scl_o <= 1'b1;
            st_q  <= ST_P_HIGH;
          end
        end
        ST_P_HIGH: if (hop) begin
          sda_o <= 1'b1;
          st_q  <= ST_P_END;
        end
        default: if (hop) st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int          TMR_W    = 16,
  parameter int          CNT_W    = 8,
  parameter logic [15:0] DIV_RST  = 16'h0052,
  parameter logic [15:0] HOLD_RST = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              scl_o,
  output logic              sda_o,
  input  logic              sda_i
);
  localparam int STAT_W = 6;

  logic [7:0]       cfg_q, ofs_q, dout_q, din_q;
  logic [6:0]       dev_q;
  logic [TMR_W-1:0] div_q, hold_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full_q, rdy_q, nack_q, serr_q;
  logic             busy_w, go_w, take_w, rxv_w, nack_w, serr_w;
  logic [7:0]       rxb_w;
  logic [STAT_W-1:0] stat_w;

  assign go_w = reg_wr && (reg_idx == IX_GO) && !busy_w && (reg_wdata[1:0] != 2'd3);
  assign stat_w = {1'b0, serr_q, nack_q, rdy_q, !full_q, busy_w};

  i2cm_engine #(.TMR_W(TMR_W), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst(rst), .go(go_w),
    .mode_in(xfer_mode_e'(reg_wdata[1:0])),
    .skip_ofs(cfg_q[CFG_SKIP_BIT]),
    .dev_addr(dev_q), .ofs_byte(ofs_q), .byte_cnt(cnt_q),
    .div_val(div_q), .hold_val(hold_q),
    .tx_byte(dout_q), .tx_full(full_q), .tx_take(take_w),
    .rx_byte(rxb_w), .rx_valid(rxv_w),
    .nack_hit(nack_w), .start_err(serr_w), .busy(busy_w),
    .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      div_q  <= TMR_W'(DIV_RST);
      hold_q <= TMR_W'(HOLD_RST);
      dev_q  <= '0;
      ofs_q  <= '0;
      dout_q <= '0;
      cnt_q  <= '0;
    end else if (reg_wr) begin
      case (reg_idx)
        IX_CFG:  cfg_q  <= reg_wdata[7:0];
        IX_DIV:  div_q  <= reg_wdata[TMR_W-1:0];
        IX_DEV:  dev_q  <= reg_wdata[6:0];
        IX_OFS:  ofs_q  <= reg_wdata[7:0];
        IX_DOUT: dout_q <= reg_wdata[7:0];
        IX_CNT:  cnt_q  <= reg_wdata[CNT_W-1:0];
        IX_HOLD: hold_q <= reg_wdata[TMR_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      rdy_q  <= 1'b0;
      din_q  <= '0;
      nack_q <= 1'b0;
      serr_q <= 1'b0;
    end else begin
      if (reg_wr && reg_idx == IX_DOUT) full_q <= 1'b1;
      else if (take_w)                  full_q <= 1'b0;

      if (rxv_w) begin
        din_q <= rxb_w;
        rdy_q <= 1'b1;
      end else if (reg_rd && reg_idx == IX_DIN) begin
        rdy_q <= 1'b0;
      end

      if (go_w)        nack_q <= 1'b0;
      else if (nack_w) nack_q <= 1'b1;

      if (go_w && !serr_w) serr_q <= 1'b0;
      else if (serr_w)     serr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_idx)
        IX_CFG:  reg_rdata <= DATA_W'(cfg_q);
        IX_DIV:  reg_rdata <= DATA_W'(div_q);
        IX_DEV:  reg_rdata <= DATA_W'(dev_q);
        IX_OFS:  reg_rdata <= DATA_W'(ofs_q);
        IX_DOUT: reg_rdata <= DATA_W'(dout_q);
        IX_DIN:  reg_rdata <= DATA_W'(din_q);
        IX_STAT: reg_rdata <= DATA_W'(stat_w);
        IX_CNT:  reg_rdata <= DATA_W'(cnt_q);
        IX_HOLD: reg_rdata <= DATA_W'(hold_q);
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/i2cm_ctrl_chk.sv
module i2cm_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic scl_o,
  input logic sda_o,
  input logic busy,
  input logic go,
  input logic full_q,
  input logic rdy_q,
  input logic nack_q,
  input logic serr_q
);
  // R2
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (scl_o && sda_o));

  // R3
  start_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_o && $past(scl_o) && $fell(sda_o)) |-> $rose(busy));

  // R12
  stop_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_o && $past(scl_o) && $rose(sda_o)) |-> busy);

  // R7
  take_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(full_q) |-> busy);

  // R8
  rx_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_q) |-> busy);

  // R10
  nack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(nack_q) && !$past(go)) |-> nack_q);

  // R11
  serr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(serr_q) |-> !busy);
endmodule

bind i2cm_ctrl i2cm_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .scl_o(scl_o), .sda_o(sda_o),
  .busy(busy_w), .go(go_w), .full_q(full_q), .rdy_q(rdy_q),
  .nack_q(nack_q), .serr_q(serr_q)
);

// File: tb/i2cm_ctrl_bench.sv
module i2cm_ctrl_bench;
  localparam int P_DIV  = 3;
  localparam int P_HOLD = 2;
  localparam logic [6:0] TADDR = 7'h50;
  localparam int EV_BYTE = 32'h100, EV_ACK = 32'h200, EV_STOP = 32'h300, EV_START = 32'h400;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic scl_o, sda_o, sda_i;
  logic t_sda = 1'b1, force_low = 1'b0, mon_off = 1'b0;

  int checks = 0, failures = 0;
  int exp_q[$];
  string tag_q[$];
  logic [7:0] tdata [4];

  always #2 clk = ~clk;
  assign sda_i = sda_o & t_sda & ~force_low;

  i2cm_ctrl u_i2cm_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic push(input int item, input string tag);
    exp_q.push_back(item);
    tag_q.push_back(tag);
  endtask

  task automatic obs(input int item);
    if (exp_q.size() == 0) chk(1'b0, "R2", item, 0);
    else begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(item == e, t, item, e);
    end
  endtask

  // target model and scoreboard monitor, sampled on the falling clock edge
  logic pscl = 1'b1, psda = 1'b1, mack = 1'b0, dir = 1'b0, tx_mode = 1'b0, first_fall = 1'b0;
  logic [7:0] rxsh = '0;
  int bitn = 0, byten = 0, tidx = 0, hi_cnt = 0;

  always @(negedge clk) begin
    if (!rst && !mon_off) begin
      if (pscl && scl_o && psda && !sda_i) begin
        obs(EV_START);
        bitn = 0; byten = 0; tx_mode = 0; dir = 0; hi_cnt = 1; first_fall = 1; t_sda = 1;
      end else if (pscl && scl_o && !psda && sda_i) begin
        obs(EV_STOP);
        t_sda = 1; tx_mode = 0;
      end else if (!pscl && scl_o) begin
        hi_cnt = 1;
        if (bitn < 8) begin
          rxsh = {rxsh[6:0], sda_i};
          bitn++;
        end else if (bitn == 8) begin
          if (tx_mode) begin
            mack = sda_i;
            obs(EV_ACK | int'(sda_i));
          end
          bitn = 9;
        end
      end else if (pscl && !scl_o) begin
        if (first_fall) chk(hi_cnt == P_HOLD + 1, "R3", hi_cnt, P_HOLD + 1);
        else            chk(hi_cnt == P_DIV + 1,  "R4", hi_cnt, P_DIV + 1);
        first_fall = 0;
        if (bitn == 8) begin
          if (!tx_mode) begin
            obs(EV_BYTE | int'(rxsh));
            if (byten == 0) dir = rxsh[0];
            t_sda = (byten == 0 && rxsh[7:1] != TADDR) ? 1'b1 : 1'b0;
          end else t_sda = 1;
        end else if (bitn == 9) begin
          bitn = 0;
          if (tx_mode && mack) tx_mode = 0;
          else if (!tx_mode && byten == 0 && dir) begin tx_mode = 1; tidx = 0; end
          else if (tx_mode) tidx++;
          byten++;
          t_sda = tx_mode ? tdata[tidx][7] : 1'b1;
        end else if (tx_mode && bitn >= 1 && bitn <= 7) begin
          t_sda = tdata[tidx][7 - bitn];
        end
      end else if (scl_o) begin
        hi_cnt++;
      end
    end
    pscl = scl_o;
    psda = sda_i;
  end

  task automatic wr(input logic [3:0] idx, input logic [15:0] val);
    @(negedge clk);
    reg_wr = 1; reg_idx = idx; reg_wdata = val;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [15:0] val);
    @(negedge clk);
    reg_rd = 1; reg_idx = idx;
    @(negedge clk);
    reg_rd = 0;
    val = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    do rd(4'd6, s); while (s[0]);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R12 watchdog act=hung exp=done");
    summary();
  end

  initial begin
    logic [15:0] v;
    tdata[0] = 8'h11; tdata[1] = 8'h22; tdata[2] = 8'h33; tdata[3] = 8'h44;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1 reset state
    rd(4'd6, v); chk(v == 16'h0002, "R1", v, 16'h0002);
    rd(4'd1, v); chk(v == 16'h0052, "R1", v, 16'h0052);
    rd(4'd9, v); chk(v == 16'h0000, "R1", v, 0);
    chk(scl_o && sda_o, "R1", {scl_o, sda_o}, 2'b11);
    wr(4'd1, P_DIV);
    wr(4'd9, P_HOLD);

    // write with offset, refilled through the empty flag (R5 R6 R7)
    push(EV_START, "R3"); push(EV_BYTE | 8'hA0, "R5"); push(EV_BYTE | 8'h10, "R6");
    push(EV_BYTE | 8'hA5, "R7"); push(EV_BYTE | 8'h3C, "R7"); push(EV_STOP, "R12");
    wr(4'd0, 16'hF8); wr(4'd2, 16'h50); wr(4'd3, 16'h10); wr(4'd8, 16'd2);
    wr(4'd4, 16'hA5); wr(4'd0 + 4'd7, 16'd0);
    rd(4'd6, v); chk(v[0] == 1'b1, "R2", v, 1);
    begin
      int sent = 1;
      do begin
        rd(4'd6, v);
        if (v[1] && sent < 2) begin wr(4'd4, 16'h3C); sent++; end
      end while (v[0]);
    end
    rd(4'd6, v); chk(v == 16'h0002, "R12", v, 16'h0002);
    chk(exp_q.size() == 0, "R12", exp_q.size(), 0);

    // data-out empty when a byte is due: SCL held low (R7), no offset (R6)
    push(EV_START, "R3"); push(EV_BYTE | 8'hA0, "R6"); push(EV_BYTE | 8'h77, "R7"); push(EV_STOP, "R12");
    wr(4'd0, 16'hFA); wr(4'd8, 16'd1); wr(4'd7, 16'd0);
    repeat (300) @(posedge clk);
    @(negedge clk) chk(scl_o == 1'b0, "R7", scl_o, 0);
    rd(4'd6, v); chk(v[1:0] == 2'b11, "R7", v, 3);
    wr(4'd4, 16'h77);
    wait_idle();
    chk(exp_q.size() == 0, "R7", exp_q.size(), 0);

    // read with offset bit clear: no offset, ACK ACK NACK (R5 R6 R8)
    push(EV_START, "R3"); push(EV_BYTE | 8'hA1, "R5"); push(EV_ACK | 0, "R8");
    push(EV_ACK | 0, "R8"); push(EV_ACK | 1, "R8"); push(EV_STOP, "R12");
    wr(4'd0, 16'hF8); wr(4'd8, 16'd3); wr(4'd7, 16'd1);
    for (int k = 0; k < 3; k++) begin
      do rd(4'd6, v); while (!v[2]);
      rd(4'd5, v); chk(v == 16'(tdata[k]), "R8", v, tdata[k]);
      rd(4'd6, v); chk(v[2] == 1'b0, "R8", v, 0);
    end
    wait_idle();
    chk(exp_q.size() == 0, "R6", exp_q.size(), 0);

    // address-only with offset, start while busy ignored (R9 R2)
    push(EV_START, "R3"); push(EV_BYTE | 8'hA0, "R9"); push(EV_BYTE | 8'h10, "R9"); push(EV_STOP, "R9");
    wr(4'd8, 16'd5); wr(4'd7, 16'd2); wr(4'd7, 16'd1);
    wait_idle();
    chk(exp_q.size() == 0, "R9", exp_q.size(), 0);

    // mode value 3 ignored (R2)
    wr(4'd7, 16'd3);
    repeat (50) @(posedge clk);
    rd(4'd6, v); chk(v[0] == 1'b0, "R2", v, 0);
    chk(scl_o && sda_o, "R2", {scl_o, sda_o}, 2'b11);

    // target does not acknowledge the address (R10)
    push(EV_START, "R3"); push(EV_BYTE | 8'h66, "R10"); push(EV_STOP, "R10");
    wr(4'd2, 16'h33); wr(4'd7, 16'd0);
    wait_idle();
    rd(4'd6, v); chk(v == 16'h000A, "R10", v, 16'h000A);
    wr(4'd8, 16'd1);
    rd(4'd6, v); chk(v[3] == 1'b1, "R10", v, 1);

    // SDA held low at start (R11)
    mon_off = 1; force_low = 1;
    wr(4'd7, 16'd0);
    repeat (20) @(posedge clk);
    rd(4'd6, v); chk(v == 16'h0012, "R11", v, 16'h0012);
    @(negedge clk) chk(scl_o == 1'b1, "R11", scl_o, 1);
    force_low = 0;
    repeat (5) @(negedge clk);
    mon_off = 0;

    // next accepted start clears the start error (R11)
    push(EV_START, "R3"); push(EV_BYTE | 8'hA0, "R5"); push(EV_STOP, "R12");
    wr(4'd2, 16'h50); wr(4'd0, 16'hFA); wr(4'd8, 16'd0); wr(4'd7, 16'd0);
    wait_idle();
    rd(4'd6, v); chk(v == 16'h0002, "R11", v, 16'h0002);
    chk(exp_q.size() == 0, "R12", exp_q.size(), 0);

    summary();
  end
endmodule